// File: doc/BRIEF.md
# Load/Store Issue Sequencer

This block models the issue stage of a processor core for single-register memory instructions. Each decoded load, store or preload hint is accepted on a valid/ready handshake. The block decides how many issue cycles the instruction occupies from its addressing mode, from whether the access may be misaligned, and, for loads that write the program counter, from whether the return-address prediction was right. It holds `in_ready` low until that count has elapsed.

For each instruction the block sends one or two memory requests, each with a byte address and an 8-bit lane mask for the 8-byte lane the request touches. It signals with single-cycle pulses when the loaded value and the written-back base register become usable by later instructions. It presents store data on a separate write-data channel once the issue window is over. Caching, real branch prediction and merging of split load data are handled elsewhere.

Top module: `ldst_issue_seq`

## Requirements
- R1: After reset `in_ready` is high and `req_valid`, `wdat_valid`, `load_rdy` and `base_rdy` are low. An instruction is accepted in a cycle where `in_valid` and `in_ready` are both high; that is cycle 0. `in_ready` next reads high in cycle N, where N is the issue count, so a one-cycle instruction can be followed by another every cycle.
- R2: N is 1 by default. Exactly one request then appears, in cycle 1. It carries the byte address and a lane mask in which bit i marks byte i of the 8-byte lane selected by address bits above bit 2.
- R3: A pre-indexed access with a register offset takes a base count of 3 instead of 1 when the offset is subtracted, or when its shift is anything other than a left shift by 1, 2 or 3. An unshifted register offset (amount 0) counts as slow.
- R4: An access is potentially misaligned when misalignment support is on, its size is halfword or word (`in_size` 0 = byte, 1 = halfword, 2 or 3 = word), and it is not a program-counter load. Such an access adds one issue cycle even when its address is aligned. A byte access never adds the cycle.
- R5: A load (`in_op` = 0) that does not target the program counter raises `load_rdy` for one cycle in cycle N+1. This gives 2, 4, 3 and 5 for the four combinations of fast/slow mode and aligned/potentially misaligned.
- R6: When `in_wback` is set and the instruction is not a program-counter load, `base_rdy` pulses in cycle N (1, 3, 2 or 4).
- R7: A potentially misaligned access whose bytes run past the end of its 8-byte lane is split. The first request, in cycle 1, covers the bytes from the start address to the lane end. The second, in cycle 2, is at the next 8-byte boundary and covers the remaining bytes from lane byte 0.
- R8: An access that is not potentially misaligned has the address bits below its size cleared, in both the request address and the lane mask.
- R9: A preload hint (`in_op` = 2, with 3 treated the same) has the timing and requests of a load but never raises `load_rdy`.
- R10: A store (`in_op` = 1) issues requests with `req_write` high. Its data is the value on `st_data` during its final issue cycle N, presented with `wdat_valid` in cycle N+1. Loads and preloads never raise `wdat_valid`.
- R11: A load with `in_to_pc` set takes N = 1 when `in_rs_ok` is high and N = 9 when it is low, regardless of mode or misalignment support. It sends one request and raises neither `load_rdy` nor `base_rdy`.
- R12: Pulses and requests of back-to-back instructions can coincide, and none is lost. An older load's `load_rdy` can share a cycle with a younger instruction's `base_rdy` and its first request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| in_valid | input | 1 | Instruction offered |
| in_ready | output | 1 | Instruction can be accepted |
| in_op | input | 2 | 0 load, 1 store, 2/3 preload hint |
| in_size | input | 2 | 0 byte, 1 halfword, 2/3 word |
| in_pre_idx | input | 1 | Pre-indexed addressing |
| in_reg_off | input | 1 | Offset comes from a register |
| in_off_neg | input | 1 | Offset is subtracted |
| in_shift_lsl | input | 1 | Offset shift is a left shift |
| in_shift_amt | input | 5 | Offset shift amount |
| in_wback | input | 1 | Base register is written back |
| in_addr | input | AW | Computed byte address |
| in_unal_en | input | 1 | Misaligned access support enabled |
| in_to_pc | input | 1 | Load destination is the program counter |
| in_rs_ok | input | 1 | Return-address prediction was correct |
| st_data | input | DW | Store data, sampled in the final issue cycle |
| req_valid | output | 1 | Memory request present |
| req_write | output | 1 | Request is a write |
| req_addr | output | AW | Request byte address |
| req_be | output | 8 | Lane byte mask |
| wdat_valid | output | 1 | Store data present |
| wdat | output | DW | Store data |
| load_rdy | output | 1 | Loaded value usable this cycle |
| base_rdy | output | 1 | Updated base usable this cycle |

## Verification
Two timing paths can fire in the same cycle: the result-ready pulse of an older load, and the base-ready pulse plus first request of a younger instruction. The bench provokes this by issuing a fast aligned load and, in the very next cycle, a fast post-indexed store with write-back. `load_rdy`, `base_rdy` and the store's request must then all appear together in cycle 2 after the load, and the store data must follow in cycle 3. The check judges the coincident cycle and also that each pulse appears exactly once, so that neither path can swallow or duplicate the other.

// File: rtl/ldst_issue_pkg.sv
package ldst_issue_pkg;

  typedef enum logic [1:0] {
    OP_LOAD    = 2'd0,
    OP_STORE   = 2'd1,
    OP_PRELOAD = 2'd2,
    OP_HINT2   = 2'd3
  } mem_op_e;

  localparam int LANE_BYTES = 8;

  // byte count for an access size code (0 byte, 1 half, 2/3 word)
  function automatic logic [3:0] size_bytes(input logic [1:0] sz);
    case (sz)
      2'd0:    size_bytes = 4'd1;
      2'd1:    size_bytes = 4'd2;
      default: size_bytes = 4'd4;
    endcase
  endfunction

endpackage

// File: rtl/ldst_timing_dec.sv
module ldst_timing_dec
  import ldst_issue_pkg::*;
#(
  parameter int PC_PENALTY = 9,
  parameter int SLOW_CYC   = 3,
  parameter int CNT_W      = 4,
  parameter int LAT_W      = 3
) (
  input  logic [1:0]       op,
  input  logic [1:0]       size,
  input  logic             pre_idx,
  input  logic             reg_off,
  input  logic             off_neg,
  input  logic             shift_lsl,
  input  logic [4:0]       shift_amt,
  input  logic             wback,
  input  logic             unal_en,
  input  logic             to_pc,
  input  logic             rs_ok,
  output logic [CNT_W-1:0] cycles,
  output logic [LAT_W-1:0] ld_lat,
  output logic [LAT_W-1:0] base_lat,
  output logic             ld_en,
  output logic             base_en,
  output logic             pot_unal,
  output logic             is_store
);

  logic             cheap_shift;
  logic             slow_mode;
  logic             pc_load;
  logic [CNT_W-1:0] core_cyc;

  always_comb begin
    cheap_shift = shift_lsl && (shift_amt >= 5'd1) && (shift_amt <= 5'd3);
    slow_mode   = pre_idx && reg_off && (off_neg || !cheap_shift);
    pc_load     = (op == OP_LOAD) && to_pc;
    pot_unal    = unal_en && (size != 2'd0) && !pc_load;
    core_cyc    = (slow_mode ? CNT_W'(SLOW_CYC) : CNT_W'(1)) + CNT_W'(pot_unal);
    if (pc_load) cycles = rs_ok ? CNT_W'(1) : CNT_W'(PC_PENALTY);
    else         cycles = core_cyc;
    ld_lat   = LAT_W'(core_cyc) + LAT_W'(1);
    base_lat = LAT_W'(core_cyc);
    ld_en    = (op == OP_LOAD) && !to_pc;
    base_en  = wback && !pc_load;
    is_store = (op == OP_STORE);
  end

endmodule

// File: rtl/ldst_lane_gen.sv
module ldst_lane_gen
  import ldst_issue_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic [AW-1:0] addr,
  input  logic [1:0]    size,
  input  logic          free_align,
  output logic [AW-1:0] a0,
  output logic [AW-1:0] a1,
  output logic [7:0]    be0,
  output logic [7:0]    be1,
  output logic          split
);

  logic [3:0]    nb;
  logic [3:0]    first;
  logic [3:0]    last;
  logic [AW-1:0] low_mask;

  always_comb begin
    nb       = size_bytes(size);
    low_mask = AW'(nb) - AW'(1);
    a0       = free_align ? addr : (addr & ~low_mask);
    first    = {1'b0, a0[2:0]};
    last     = first + nb - 4'd1;
    for (int i = 0; i < LANE_BYTES; i++) begin
      be0[i] = (4'(i) >= first) && (4'(i) <= last);
      be1[i] = (4'(i + LANE_BYTES) <= last);
    end
    split = free_align && last[3];
    a1    = {a0[AW-1:3] + 1'b1, 3'b000};
  end

endmodule

// File: rtl/ldst_pulse_sched.sv
module ldst_pulse_sched #(
  parameter int DEPTH = 5,
  parameter int LAT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fire,
  input  logic [LAT_W-1:0] lat,
  output logic             pulse
);

  logic [DEPTH-1:0] sr_q;
  logic [DEPTH-1:0] sr_d;
  logic [DEPTH-1:0] ins;

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    assign ins[g] = fire && (lat == LAT_W'(g + 1));
  end

  always_comb sr_d = (sr_q >> 1) | ins;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr_q <= '0;
    else        sr_q <= sr_d;
  end

  assign pulse = sr_q[0];

endmodule

// File: rtl/ldst_issue_seq.sv
module ldst_issue_seq
  import ldst_issue_pkg::*;
#(
  parameter int AW         = 32,
  parameter int DW         = 32,
  parameter int PC_PENALTY = 9,
  parameter int SLOW_CYC   = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [1:0]    in_op,
  input  logic [1:0]    in_size,
  input  logic          in_pre_idx,
  input  logic          in_reg_off,
  input  logic          in_off_neg,
  input  logic          in_shift_lsl,
  input  logic [4:0]    in_shift_amt,
  input  logic          in_wback,
  input  logic [AW-1:0] in_addr,
  input  logic          in_unal_en,
  input  logic          in_to_pc,
  input  logic          in_rs_ok,
  input  logic [DW-1:0] st_data,
  output logic          req_valid,
  output logic          req_write,
  output logic [AW-1:0] req_addr,
  output logic [7:0]    req_be,
  output logic          wdat_valid,
  output logic [DW-1:0] wdat,
  output logic          load_rdy,
  output logic          base_rdy
);

  localparam int MAX_CYC = (PC_PENALTY > SLOW_CYC + 1) ? PC_PENALTY : SLOW_CYC + 1;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);
  localparam int DEPTH   = SLOW_CYC + 2;
  localparam int LAT_W   = $clog2(DEPTH + 1);

  logic [CNT_W-1:0] dec_cycles;
  logic [LAT_W-1:0] dec_ld_lat, dec_base_lat;
  logic             dec_ld_en, dec_base_en, dec_pot, dec_store;
  logic [AW-1:0]    lg_a0, lg_a1;
  logic [7:0]       lg_be0, lg_be1;
  logic             lg_split;

  ldst_timing_dec #(
    .PC_PENALTY(PC_PENALTY), .SLOW_CYC(SLOW_CYC), .CNT_W(CNT_W), .LAT_W(LAT_W)
  ) u_dec (
    .op(in_op), .size(in_size), .pre_idx(in_pre_idx), .reg_off(in_reg_off),
    .off_neg(in_off_neg), .shift_lsl(in_shift_lsl), .shift_amt(in_shift_amt),
    .wback(in_wback), .unal_en(in_unal_en), .to_pc(in_to_pc), .rs_ok(in_rs_ok),
    .cycles(dec_cycles), .ld_lat(dec_ld_lat), .base_lat(dec_base_lat),
    .ld_en(dec_ld_en), .base_en(dec_base_en), .pot_unal(dec_pot), .is_store(dec_store)
  );

  ldst_lane_gen #(.AW(AW)) u_lane (
    .addr(in_addr), .size(in_size), .free_align(dec_pot),
    .a0(lg_a0), .a1(lg_a1), .be0(lg_be0), .be1(lg_be1), .split(lg_split)
  );

  logic accept;
  assign accept = in_valid && in_ready;

  ldst_pulse_sched #(.DEPTH(DEPTH), .LAT_W(LAT_W)) u_ld_sched (
    .clk(clk), .rst_n(rst_n), .fire(accept && dec_ld_en),
    .lat(dec_ld_lat), .pulse(load_rdy)
  );

  ldst_pulse_sched #(.DEPTH(DEPTH), .LAT_W(LAT_W)) u_base_sched (
    .clk(clk), .rst_n(rst_n), .fire(accept && dec_base_en),
    .lat(dec_base_lat), .pulse(base_rdy)
  );

  // control state
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             st_pend_q, st_pend_d;
  logic             wd_take;
  logic             wdv_q, wdv_d;
  logic             reqv_q, reqv_d;
  logic             pend_q, pend_d;
  // data state with enables
  logic             req_en, pend_en;
  logic [AW-1:0]    req_a_q, req_a_d, pend_a_q;
  logic [7:0]       req_b_q, req_b_d, pend_b_q;
  logic             req_w_q;
  logic [DW-1:0]    wdat_q;

  assign in_ready = (cnt_q <= CNT_W'(1));

  always_comb begin
    cnt_d = cnt_q;
    if (accept)               cnt_d = dec_cycles;
    else if (cnt_q != '0)     cnt_d = cnt_q - CNT_W'(1);

    wd_take   = st_pend_q && (cnt_q == CNT_W'(1));
    wdv_d     = wd_take;
    st_pend_d = st_pend_q;
    if (accept)       st_pend_d = dec_store;
    else if (wd_take) st_pend_d = 1'b0;

    reqv_d  = 1'b0;
    pend_d  = pend_q;
    req_en  = 1'b0;
    pend_en = 1'b0;
    req_a_d = req_a_q;
    req_b_d = req_b_q;
    if (accept) begin
      reqv_d  = 1'b1;
      req_en  = 1'b1;
      pend_en = 1'b1;
      req_a_d = lg_a0;
      req_b_d = lg_be0;
      pend_d  = lg_split;
    end else if (pend_q) begin
      reqv_d  = 1'b1;
      req_en  = 1'b1;
      req_a_d = pend_a_q;
      req_b_d = pend_b_q;
      pend_d  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q     <= '0;
      st_pend_q <= 1'b0;
      wdv_q     <= 1'b0;
      reqv_q    <= 1'b0;
      pend_q    <= 1'b0;
    end else begin
      cnt_q     <= cnt_d;
      st_pend_q <= st_pend_d;
      wdv_q     <= wdv_d;
      reqv_q    <= reqv_d;
      pend_q    <= pend_d;
    end
  end

  always_ff @(posedge clk) begin
    if (req_en) begin
      req_a_q <= req_a_d;
      req_b_q <= req_b_d;
    end
    if (accept)  req_w_q  <= dec_store;
    if (pend_en) begin
      pend_a_q <= lg_a1;
      pend_b_q <= lg_be1;
    end
    if (wd_take) wdat_q <= st_data;
  end

  assign req_valid  = reqv_q;
  assign req_write  = req_w_q;
  assign req_addr   = req_a_q;
  assign req_be     = req_b_q;
  assign wdat_valid = wdv_q;
  assign wdat       = wdat_q;

endmodule

// File: rtl/ldst_issue_chk.sv
module ldst_issue_chk
  import ldst_issue_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       in_valid,
  input logic       in_ready,
  input logic [1:0] in_op,
  input logic [1:0] in_size,
  input logic       in_pre_idx,
  input logic       in_unal_en,
  input logic       in_to_pc,
  input logic       in_rs_ok,
  input logic       req_valid,
  input logic [7:0] req_be,
  input logic       wdat_valid,
  input logic       load_rdy
);

  logic acc;
  assign acc = in_valid && in_ready;

  // R1
  accept_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> req_valid);

  // R2
  req_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (req_be != 8'h00));

  // R4
  unal_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && in_unal_en && (in_size != 2'd0) && !in_to_pc) |=> !in_ready);

  // R5
  fast_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && (in_op == OP_LOAD) && !in_pre_idx && !in_unal_en && !in_to_pc)
      |=> ##1 load_rdy);

  // R10
  fast_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && (in_op == OP_STORE) && !in_pre_idx && !in_unal_en) |=> ##1 wdat_valid);

  // R11
  pc_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && (in_op == OP_LOAD) && in_to_pc && !in_rs_ok) |=> !in_ready);

endmodule

bind ldst_issue_seq ldst_issue_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_op(in_op), .in_size(in_size), .in_pre_idx(in_pre_idx),
  .in_unal_en(in_unal_en), .in_to_pc(in_to_pc), .in_rs_ok(in_rs_ok),
  .req_valid(req_valid), .req_be(req_be), .wdat_valid(wdat_valid),
  .load_rdy(load_rdy)
);

// File: tb/sim_ldst_issue_seq.sv
module sim_ldst_issue_seq;
  import ldst_issue_pkg::*;

  localparam int CLK_PERIOD = 10;

  logic        clk, rst_n, in_valid, in_ready;
  logic [1:0]  in_op, in_size;
  logic        in_pre_idx, in_reg_off, in_off_neg, in_shift_lsl;
  logic [4:0]  in_shift_amt;
  logic        in_wback, in_unal_en, in_to_pc, in_rs_ok;
  logic [31:0] in_addr, st_data, req_addr, wdat;
  logic        req_valid, req_write, wdat_valid, load_rdy, base_rdy;
  logic [7:0]  req_be;

  ldst_issue_seq u0 (.*);

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk) st_data <= 32'hD000_0000 + cyc;

  int checks = 0, errors = 0;

  // event log, offsets relative to the acceptance cycle (cycle 0)
  bit          logging = 0;
  int          acc;
  int          nreq, ld_o, ld_n, bs_o, bs_n, wd_o, wd_n, rdy_o, both_o;
  int          rq_o [4];
  logic [31:0] rq_a [4];
  logic [7:0]  rq_b [4];
  logic        rq_w [4];
  logic [31:0] wd_d;

  always @(negedge clk) begin
    if (logging) begin
      int off;
      off = cyc - acc + 1;
      if (req_valid && nreq < 4) begin
        rq_o[nreq] = off; rq_a[nreq] = req_addr; rq_b[nreq] = req_be; rq_w[nreq] = req_write;
        nreq++;
      end
      if (load_rdy) begin if (ld_n == 0) ld_o = off; ld_n++; end
      if (base_rdy) begin if (bs_n == 0) bs_o = off; bs_n++; end
      if (wdat_valid) begin if (wd_n == 0) begin wd_o = off; wd_d = wdat; end wd_n++; end
      if (in_ready && rdy_o < 0) rdy_o = off;
      if (load_rdy && base_rdy && both_o < 0) both_o = off;
    end
  end

  task automatic chk(string tag, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic summary;
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL R1 watchdog: actual=hung expected=finished");
    summary();
    $finish;
  end

  typedef struct {
    logic [1:0] op, size;
    bit pre, rg, neg, lsl;
    logic [4:0] amt;
    bit wb;
    logic [31:0] addr;
    bit unal, pc, rs;
  } ins_t;

  function automatic ins_t mk(logic [1:0] op, logic [1:0] size, bit pre, bit rg, bit neg,
                              bit lsl, logic [4:0] amt, bit wb, logic [31:0] addr,
                              bit unal, bit pc, bit rs);
    ins_t x;
    x.op = op; x.size = size; x.pre = pre; x.rg = rg; x.neg = neg; x.lsl = lsl;
    x.amt = amt; x.wb = wb; x.addr = addr; x.unal = unal; x.pc = pc; x.rs = rs;
    return x;
  endfunction

  task automatic put(ins_t x);
    in_op = x.op; in_size = x.size; in_pre_idx = x.pre; in_reg_off = x.rg;
    in_off_neg = x.neg; in_shift_lsl = x.lsl; in_shift_amt = x.amt; in_wback = x.wb;
    in_addr = x.addr; in_unal_en = x.unal; in_to_pc = x.pc; in_rs_ok = x.rs;
  endtask

  task automatic clear_log;
    nreq = 0; ld_n = 0; bs_n = 0; wd_n = 0; ld_o = -1; bs_o = -1; wd_o = -1;
    rdy_o = -1; both_o = -1; wd_d = '0;
  endtask

  // issue one instruction, log 14 cycles
  task automatic issue(ins_t x);
    @(negedge clk);
    put(x);
    in_valid = 1'b1;
    @(posedge clk); #1;
    acc = cyc;
    clear_log();
    logging = 1;
    in_valid = 1'b0;
    repeat (14) @(negedge clk);
    logging = 0;
  endtask

  // generic judgement of one logged instruction; l/b of 0 mean no pulse
  task automatic judge(string tag, int n, int l, int b, int nr,
                       logic [31:0] a0, logic [7:0] be0, logic [31:0] a1, logic [7:0] be1,
                       bit st);
    chk(tag, "ready cycle", rdy_o, n);
    chk(tag, "load pulses", ld_n, (l != 0) ? 1 : 0);
    if (l != 0) chk(tag, "load cycle", ld_o, l);
    chk(tag, "base pulses", bs_n, (b != 0) ? 1 : 0);
    if (b != 0) chk(tag, "base cycle", bs_o, b);
    chk(tag, "request count", nreq, nr);
    if (nreq >= 1) begin
      chk(tag, "req0 cycle", rq_o[0], 1);
      chk(tag, "req0 addr", rq_a[0], a0);
      chk(tag, "req0 mask", rq_b[0], be0);
      chk(tag, "req0 write", rq_w[0], st);
    end
    if (nr == 2 && nreq >= 2) begin
      chk(tag, "req1 cycle", rq_o[1], 2);
      chk(tag, "req1 addr", rq_a[1], a1);
      chk(tag, "req1 mask", rq_b[1], be1);
    end
    chk(tag, "wdata count", wd_n, st ? 1 : 0);
    if (st) begin
      chk(tag, "wdata cycle", wd_o, n + 1);
      chk(tag, "wdata late", wd_d, 32'hD000_0000 + acc + n - 1);
    end
  endtask

  task automatic t_reset;
    chk("R1", "ready after reset", in_ready, 1);
    chk("R1", "req idle", req_valid, 0);
    chk("R1", "wdat idle", wdat_valid, 0);
    chk("R1", "pulses idle", {load_rdy, base_rdy}, 0);
  endtask

  task automatic t_fast;
    issue(mk(0, 2, 0, 0, 0, 0, 0, 1, 32'h1000, 0, 0, 0));
    judge("R2_R5_R6", 1, 2, 1, 1, 32'h1000, 8'h0F, 0, 0, 0);
    issue(mk(0, 2, 1, 1, 0, 1, 2, 1, 32'h1010, 0, 0, 0));
    judge("R3 fast shift", 1, 2, 1, 1, 32'h1010, 8'h0F, 0, 0, 0);
  endtask

  task automatic t_slow;
    issue(mk(0, 2, 1, 1, 1, 1, 2, 1, 32'h2004, 0, 0, 0));
    judge("R3 negative", 3, 4, 3, 1, 32'h2004, 8'hF0, 0, 0, 0);
    issue(mk(0, 2, 1, 1, 0, 1, 4, 0, 32'h2010, 0, 0, 0));
    judge("R3 wide shift", 3, 4, 0, 1, 32'h2010, 8'h0F, 0, 0, 0);
  endtask

  task automatic t_unal;
    issue(mk(0, 2, 0, 0, 0, 0, 0, 1, 32'h3000, 1, 0, 0));
    judge("R4 aligned", 2, 3, 2, 1, 32'h3000, 8'h0F, 0, 0, 0);
    issue(mk(0, 2, 0, 0, 0, 0, 0, 0, 32'h3002, 1, 0, 0));
    judge("R4 inside lane", 2, 3, 0, 1, 32'h3002, 8'h3C, 0, 0, 0);
    issue(mk(0, 0, 0, 0, 0, 0, 0, 0, 32'h6007, 1, 0, 0));
    judge("R4 byte", 1, 2, 0, 1, 32'h6007, 8'h80, 0, 0, 0);
  endtask

  task automatic t_split;
    issue(mk(0, 2, 0, 0, 0, 0, 0, 1, 32'h4006, 1, 0, 0));
    judge("R7 fast", 2, 3, 2, 2, 32'h4006, 8'hC0, 32'h4008, 8'h03, 0);
    issue(mk(0, 1, 1, 1, 1, 0, 0, 1, 32'h4007, 1, 0, 0));
    judge("R7_R5 slow", 4, 5, 4, 2, 32'h4007, 8'h80, 32'h4008, 8'h01, 0);
  endtask

  task automatic t_forced_align;
    issue(mk(0, 2, 0, 0, 0, 0, 0, 0, 32'h5003, 0, 0, 0));
    judge("R8 word", 1, 2, 0, 1, 32'h5000, 8'h0F, 0, 0, 0);
    issue(mk(0, 1, 0, 0, 0, 0, 0, 0, 32'h5007, 0, 0, 0));
    judge("R8 half", 1, 2, 0, 1, 32'h5006, 8'hC0, 0, 0, 0);
  endtask

  task automatic t_preload;
    issue(mk(2, 2, 0, 0, 0, 0, 0, 1, 32'h7000, 0, 0, 0));
    judge("R9 fast", 1, 0, 1, 1, 32'h7000, 8'h0F, 0, 0, 0);
    issue(mk(3, 1, 1, 1, 1, 0, 0, 0, 32'h7001, 1, 0, 0));
    judge("R9 slow", 4, 0, 0, 1, 32'h7001, 8'h06, 0, 0, 0);
  endtask

  task automatic t_store;
    issue(mk(1, 2, 0, 0, 0, 0, 0, 1, 32'h8004, 0, 0, 0));
    judge("R10 fast", 1, 0, 1, 1, 32'h8004, 8'hF0, 0, 0, 1);
    issue(mk(1, 2, 1, 1, 1, 0, 0, 0, 32'h8005, 1, 0, 0));
    judge("R10_R7 slow split", 4, 0, 0, 2, 32'h8005, 8'hE0, 32'h8008, 8'h01, 1);
    chk("R10 split write", "req1 write", rq_w[1], 1);
  endtask

  task automatic t_pc;
    issue(mk(0, 2, 0, 0, 0, 0, 0, 1, 32'h9000, 0, 1, 1));
    judge("R11 hit", 1, 0, 0, 1, 32'h9000, 8'h0F, 0, 0, 0);
    issue(mk(0, 2, 1, 1, 1, 0, 0, 1, 32'h9008, 1, 1, 0));
    judge("R11 miss", 9, 0, 0, 1, 32'h9008, 8'h0F, 0, 0, 0);
  endtask

  task automatic t_overlap;
    @(negedge clk);
    put(mk(0, 2, 0, 0, 0, 0, 0, 0, 32'hA000, 0, 0, 0));
    in_valid = 1'b1;
    @(posedge clk); #1;
    acc = cyc;
    clear_log();
    logging = 1;
    put(mk(1, 2, 0, 0, 0, 0, 0, 1, 32'hA010, 0, 0, 0));
    @(posedge clk); #1;
    in_valid = 1'b0;
    repeat (14) @(negedge clk);
    logging = 0;
    chk("R12", "coincident pulse cycle", both_o, 2);
    chk("R12", "load pulses", ld_n, 1);
    chk("R12", "base pulses", bs_n, 1);
    chk("R12", "request count", nreq, 2);
    chk("R12", "younger req cycle", rq_o[1], 2);
    chk("R12", "younger req addr", rq_a[1], 32'hA010);
    chk("R12", "younger req write", rq_w[1], 1);
    chk("R12", "store data cycle", wd_o, 3);
  endtask

  initial begin
    rst_n = 1'b0; in_valid = 1'b0;
    put(mk(0, 0, 0, 0, 0, 0, 0, 0, 32'h0, 0, 0, 0));
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_fast();
    t_slow();
    t_unal();
    t_split();
    t_forced_align();
    t_preload();
    t_store();
    t_pc();
    t_overlap();
    repeat (4) @(negedge clk);
    summary();
    $finish;
  end

endmodule